// File: doc/BRIEF.md
# Per-Core Performance Counter Unit

This block counts hardware events for one processor core. It has a free-running cycle counter and a parameterised bank of 32-bit event counters. Each event counter watches one line of a pulse vector, chosen by its event number. It can also be told to ignore pulses that arrive while the core runs at certain privilege levels. When any counter wraps past its maximum value, a sticky overflow flag is set. A single interrupt line is raised while any flagged counter also has its interrupt enabled.

Software reaches the unit through a plain register port. Enable state and interrupt-enable state are kept as bitmaps, and they change only through separate set and clear registers. Event counters are reached indirectly: a select register names one counter, and a type register and a value register then act on that counter. A control register gives a global run bit, one-shot reset commands, a divide-by-64 option for the cycle counter and a stop-while-debugging option. A user-access register decides whether code at the lowest privilege level may use the port at all.

The register port has no back-pressure. A read or write is accepted in the cycle it is presented, and every read returns exactly one result, one cycle later.

Top module: `pmu_unit`

## Requirements
- R1: After reset, every counter, bitmap, type register and the select register read 0. The control register (address 0) reads 0x2000 with the defaults: bits 15:11 hold NUM_EVT (4), and only bits 0, 3, 4 and 5 store what is written. Bits 1 and 2 are commands and always read 0.
- R2: Event counter n (n < NUM_EVT) adds one in a cycle only when all of the following hold:
  - control bit 0 is set;
  - bitmap bit n is set;
  - event line `evt_in[type[9:0]]` is high;
  - the privilege filter allows the current level.

  An event number of EV_LINES or more never counts. The counter wraps from 0xFFFFFFFF to 0.
- R3: The privilege filter uses the type register bits as follows:
  - type bit 30 set blocks level 0;
  - type bit 31 set blocks level 1;
  - level 2 counts only when type bit 27 is set;
  - level 3 never counts.
- R4: Enables use two registers, set (address 1) and clear (address 2). In both, bit n is event counter n and bit 31 is the cycle counter.
  - Writing 1s to the set register sets the matching bits.
  - Writing 1s to the clear register clears them.
  - 0 bits in either write change nothing.
  - Both registers read back the current mask.
  - Bits with no counter behind them always read 0.
- R5: Interrupt enables work the same way, through set (address 3) and clear (address 4). `irq` is high one cycle after a flag and its interrupt enable are both set, and stays high while that remains so.
- R6: The overflow register is at address 5. A counter wrapping sets its flag, using the same bit positions as the enables. Writing 1s clears the matching flags and 0s leave them alone. A wrap in the same cycle as a clear of that bit leaves the flag set.
- R7: The select register is at address 6. The type register (address 7) and the value register (address 8) act on the counter it names. If the selected number is NUM_EVT or higher, writes to addresses 7 and 8 are dropped and reads of them return 0.
- R8: The type register stores only the bits in mask 0xC80003FF.
- R9: The cycle counter is at address 9. It adds one per clock while control bit 0 and bitmap bit 31 are set.
  - With control bit 3 set, it adds one every 64 such clocks.
  - With control bit 5 set, it holds while `dbg_halt` is high.
  - Writing the cycle counter, or the cycle-reset command, restarts the divide-by-64 phase.
- R10: Writing control bit 1 as 1 clears every event counter. Writing control bit 2 as 1 clears the cycle counter. Overflow flags are not affected.
- R11: A write takes effect at the next clock edge. A read returns the state held before that edge, so a counter read in the cycle it increments shows the old value. `reg_rvalid` is high in the following cycle.
- R12: The user-access register is at address 10 (4 bits). While `priv` is 0 and bit 0 of this register is 0, port writes are dropped and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High the cycle after a read strobe |
| evt_in | input | EV_LINES | Event pulse vector, one bit per event number |
| priv | input | 2 | Current privilege level (0 to 3) |
| dbg_halt | input | 1 | Core is halted for debug |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Each write lands at the clock edge it is presented on. A read launched at a falling edge therefore reports, at the next falling edge, the state before that rising edge. The bench queues the expected word when it launches the read, and pops and compares it on the `reg_rvalid` sample. Counter results are due one rising edge per pulse or per enabled clock. For example, a run bit written and then cleared after M idle cycles gives exactly M+1 cycle-counter increments. `irq` is checked at the falling edge after the write that changes a flag or an interrupt enable.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  typedef enum logic [3:0] {
    A_CTRL   = 4'd0,
    A_EN_SET = 4'd1,
    A_EN_CLR = 4'd2,
    A_IE_SET = 4'd3,
    A_IE_CLR = 4'd4,
    A_OVF    = 4'd5,
    A_SEL    = 4'd6,
    A_TYPE   = 4'd7,
    A_VAL    = 4'd8,
    A_CYC    = 4'd9,
    A_UACC   = 4'd10
  } reg_addr_e;

  localparam logic [31:0] TYPE_KEEP = 32'hC800_03FF;
  localparam int CYC_BIT = 31;
  localparam int CTL_RUN = 0;
  localparam int CTL_EVRST = 1;
  localparam int CTL_CYRST = 2;
  localparam int CTL_DIV = 3;
  localparam int CTL_DBG = 5;
  localparam logic [5:0] CTL_STORE = 6'b111001;

  // privilege filter: which levels a type word lets through
  function automatic logic priv_ok(input logic [31:0] t, input logic [1:0] p);
    case (p)
      2'd0: return !t[30];
      2'd1: return !t[31];
      2'd2: return t[27];
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pmu_setclr.sv
module pmu_setclr #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] set_m, clr_m;
  assign set_m = set_we ? wdata : '0;
  assign clr_m = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q | set_m) & ~clr_m & KEEP;
  end
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter
  import pmu_pkg::*;
#(
  parameter int EV_LINES = 32,
  localparam int IDX_W = (EV_LINES > 1) ? $clog2(EV_LINES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [EV_LINES-1:0] evt,
  input  logic [1:0]          priv,
  input  logic                run,
  input  logic                clr,
  input  logic                wr_type,
  input  logic                wr_val,
  input  logic [31:0]         wdata,
  output logic [31:0]         type_q,
  output logic [31:0]         cnt_q,
  output logic                wrap
);
  logic [9:0] evnum;
  logic hit, inc;

  assign evnum = type_q[9:0];
  assign hit   = (int'(evnum) < EV_LINES) && evt[evnum[IDX_W-1:0]];
  assign inc   = run && hit && priv_ok(type_q, priv);
  assign wrap  = inc && !clr && !wr_val && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_type) type_q <= wdata & TYPE_KEEP;
      if (clr)         cnt_q <= '0;
      else if (wr_val) cnt_q <= wdata;
      else if (inc)    cnt_q <= cnt_q + 32'd1;
    end
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int PRE_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        div64,
  input  logic        clr,
  input  logic        wr_val,
  input  logic [31:0] wdata,
  output logic [31:0] cnt_q,
  output logic        wrap
);
  logic [PRE_W-1:0] pre_q;
  logic step;

  assign step = run && (!div64 || (pre_q == '1));
  assign wrap = step && !clr && !wr_val && (cnt_q == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (clr || wr_val)     pre_q <= '0;
      else if (run && div64) pre_q <= pre_q + 1'b1;
      if (clr)         cnt_q <= '0;
      else if (wr_val) cnt_q <= wdata;
      else if (step)   cnt_q <= cnt_q + 32'd1;
    end
  end
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
#(
  parameter int NUM_EVT  = 4,
  parameter int EV_LINES = 32,
  localparam int SEL_W = 5,
  localparam logic [31:0] IMPL_MASK = 32'h8000_0000 | ((32'd1 << NUM_EVT) - 32'd1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                reg_rvalid,
  input  logic [EV_LINES-1:0] evt_in,
  input  logic [1:0]          priv,
  input  logic                dbg_halt,
  output logic                irq
);
  logic access_ok, wr_ok, rd_ok;
  logic [5:0] ctrl_q;
  logic [SEL_W-1:0] sel_q;
  logic [3:0] uacc_q;
  logic sel_hit;
  logic [31:0] en_q, ie_q, ovf_q, wrap_vec, cyc_q, ovf_clr;
  logic [31:0] type_arr [NUM_EVT];
  logic [31:0] cnt_arr  [NUM_EVT];
  logic evt_rst, cyc_rst, cyc_run, cyc_wrap;
  logic [31:0] sel_type, sel_cnt, rd_mux;

  assign access_ok = (priv != 2'd0) || uacc_q[0];
  assign wr_ok = reg_wr && access_ok;
  assign rd_ok = reg_rd && access_ok;

  function automatic logic we(input reg_addr_e a);
    return wr_ok && (reg_addr == a);
  endfunction

  assign sel_hit = (int'(sel_q) < NUM_EVT);
  assign evt_rst = we(A_CTRL) && reg_wdata[CTL_EVRST];
  assign cyc_rst = we(A_CTRL) && reg_wdata[CTL_CYRST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      uacc_q <= '0;
    end else begin
      if (we(A_CTRL)) ctrl_q <= reg_wdata[5:0] & CTL_STORE;
      if (we(A_SEL))  sel_q  <= reg_wdata[SEL_W-1:0];
      if (we(A_UACC)) uacc_q <= reg_wdata[3:0];
    end
  end

  pmu_setclr #(.W(32), .KEEP(IMPL_MASK)) u_en (
    .clk(clk), .rst_n(rst_n), .set_we(we(A_EN_SET)), .clr_we(we(A_EN_CLR)),
    .wdata(reg_wdata), .q(en_q)
  );
  pmu_setclr #(.W(32), .KEEP(IMPL_MASK)) u_ie (
    .clk(clk), .rst_n(rst_n), .set_we(we(A_IE_SET)), .clr_we(we(A_IE_CLR)),
    .wdata(reg_wdata), .q(ie_q)
  );

  for (genvar g = 0; g < 31; g++) begin : g_slot
    if (g < NUM_EVT) begin : g_cnt
      logic sel_me;
      assign sel_me = sel_hit && (sel_q == SEL_W'(g));
      pmu_evt_counter #(.EV_LINES(EV_LINES)) u_ctr (
        .clk(clk), .rst_n(rst_n), .evt(evt_in), .priv(priv),
        .run(ctrl_q[CTL_RUN] && en_q[g]), .clr(evt_rst),
        .wr_type(we(A_TYPE) && sel_me), .wr_val(we(A_VAL) && sel_me),
        .wdata(reg_wdata), .type_q(type_arr[g]), .cnt_q(cnt_arr[g]),
        .wrap(wrap_vec[g])
      );
    end else begin : g_none
      assign wrap_vec[g] = 1'b0;
    end
  end

  assign cyc_run = ctrl_q[CTL_RUN] && en_q[CYC_BIT] && !(ctrl_q[CTL_DBG] && dbg_halt);

  pmu_cycle_counter #(.PRE_W(6)) u_cyc (
    .clk(clk), .rst_n(rst_n), .run(cyc_run), .div64(ctrl_q[CTL_DIV]),
    .clr(cyc_rst), .wr_val(we(A_CYC)), .wdata(reg_wdata),
    .cnt_q(cyc_q), .wrap(cyc_wrap)
  );
  assign wrap_vec[CYC_BIT] = cyc_wrap;

  // sticky overflow flags: a wrap wins over a clear in the same cycle
  assign ovf_clr = we(A_OVF) ? reg_wdata : '0;
  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= '0;
    else        ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
  end

  assign irq = |(ovf_q & ie_q);

  always_comb begin
    sel_type = '0;
    sel_cnt  = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_type = type_arr[i];
        sel_cnt  = cnt_arr[i];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:             rd_mux = {16'b0, 5'(NUM_EVT), 5'b0, ctrl_q};
      A_EN_SET, A_EN_CLR: rd_mux = en_q;
      A_IE_SET, A_IE_CLR: rd_mux = ie_q;
      A_OVF:              rd_mux = ovf_q;
      A_SEL:              rd_mux = {{(32-SEL_W){1'b0}}, sel_q};
      A_TYPE:             rd_mux = sel_type;
      A_VAL:              rd_mux = sel_cnt;
      A_CYC:              rd_mux = cyc_q;
      A_UACC:             rd_mux = {28'b0, uacc_q};
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rdata  <= rd_ok ? rd_mux : '0;
      reg_rvalid <= reg_rd;
    end
  end
endmodule

// File: rtl/pmu_unit_chk.sv
module pmu_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [3:0]  reg_addr,
  input logic        reg_rvalid,
  input logic        irq,
  input logic [31:0] en_q,
  input logic [31:0] ie_q,
  input logic [31:0] ovf_q,
  input logic        glob_en,
  input logic [31:0] cyc_q
);
  // R11: every read strobe yields a result one cycle later, and only then
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R4: the enable map only moves through its set/clear pair
  p_en_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == 4'd1 || reg_addr == 4'd2)) |=> $stable(en_q));

  // R6: flags are sticky unless the overflow register is written
  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 4'd5) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  // R5: the line needs at least one interrupt enable
  p_irq_needs_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie_q != 32'd0));

  // R9: with the run bit clear and no write, the cycle counter holds
  p_cyc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !reg_wr) |=> $stable(cyc_q));
endmodule

bind pmu_unit pmu_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rvalid(reg_rvalid), .irq(irq),
  .en_q(en_q), .ie_q(ie_q), .ovf_q(ovf_q), .glob_en(ctrl_q[0]), .cyc_q(cyc_q)
);

// File: tb/pmu_unit_test.sv
module pmu_unit_test;
  localparam int NUM_EVT = 4;
  localparam int EV_LINES = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid;
  logic [EV_LINES-1:0] evt_in = '0;
  logic [1:0] priv = 2'd1;
  logic dbg_halt = 1'b0;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  pmu_unit #(.NUM_EVT(NUM_EVT), .EV_LINES(EV_LINES)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .evt_in(evt_in), .priv(priv),
    .dbg_halt(dbg_halt), .irq(irq)
  );

  localparam logic [3:0] CTRL = 0, EN_SET = 1, EN_CLR = 2, IE_SET = 3, IE_CLR = 4,
    OVF = 5, SEL = 6, TYP = 7, VAL = 8, CYC = 9, UACC = 10;

  // monitor: pop one expected word per returned read
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      vectors++;
      if (sb.size() == 0) begin
        miscompares++;
        $display("FAIL unexpected read result: actual %h expected none", reg_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (reg_rdata !== e.v) begin
          miscompares++;
          $display("FAIL %s: actual %h expected %h", e.tag, reg_rdata, e.v);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    sb.push_back(x);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input int line, input logic [1:0] p);
    evt_in[line] = 1'b1; priv = p;
    @(negedge clk);
    evt_in = '0; priv = 2'd1;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic run_for(input int m);
    wr(CTRL, 32'h1);
    repeat (m) @(negedge clk);
    wr(CTRL, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(CTRL, 32'h2000, "R1 ctrl after reset");
    rd(EN_SET, 32'h0, "R1 enables after reset");
    rd(OVF, 32'h0, "R1 flags after reset");
    rd(CYC, 32'h0, "R1 cycle counter after reset");
    chk_irq(1'b0, "R1 irq after reset");
    // R8 type mask
    wr(SEL, 0);
    wr(TYP, 32'hFFFF_FFFF);
    rd(TYP, 32'hC800_03FF, "R8 type keep mask");
    wr(TYP, 32'h3);
    wr(EN_SET, 32'h1);
    wr(CTRL, 32'h1);
    // R2 counting on the selected line only
    repeat (5) pulse(3, 2'd1);
    pulse(2, 2'd1);
    rd(VAL, 32'd5, "R2 five pulses on line 3");
    rd(EN_CLR, 32'h1, "R4 clear register reads mask");
    // R3 privilege filter
    wr(TYP, 32'h8000_0003);
    repeat (2) pulse(3, 2'd1);
    pulse(3, 2'd0);
    pulse(3, 2'd2);
    rd(VAL, 32'd6, "R3 level1 excluded, level2 not included");
    wr(TYP, 32'h0800_0003);
    pulse(3, 2'd2);
    pulse(3, 2'd3);
    pulse(3, 2'd0);
    rd(VAL, 32'd8, "R3 level2 included, level3 never");
    // R2 enable gating
    wr(EN_CLR, 32'h1);
    pulse(3, 2'd1);
    rd(VAL, 32'd8, "R2 cleared enable blocks count");
    wr(EN_SET, 32'h1);
    wr(CTRL, 32'h0);
    pulse(3, 2'd1);
    rd(VAL, 32'd8, "R2 global run off blocks count");
    wr(CTRL, 32'h1);
    pulse(3, 2'd1);
    rd(VAL, 32'd9, "R2 count resumes");
    // R11 read in the increment cycle sees the old value
    begin
      exp_t x;
      x.v = 32'd9; x.tag = "R11 read during increment";
      sb.push_back(x);
      reg_rd = 1'b1; reg_addr = VAL; evt_in[3] = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; evt_in = '0;
    end
    rd(VAL, 32'd10, "R11 increment visible next read");
    // R4 bitmap bits
    wr(EN_SET, 32'hFFFF_FFFF);
    rd(EN_SET, 32'h8000_000F, "R4 only implemented bits set");
    wr(EN_CLR, 32'h8000_000E);
    rd(EN_SET, 32'h1, "R4 clear leaves zero-bits alone");
    // R7 select
    wr(SEL, 5);
    wr(VAL, 32'h1234);
    rd(VAL, 32'h0, "R7 out-of-range value reads zero");
    rd(TYP, 32'h0, "R7 out-of-range type reads zero");
    wr(SEL, 3);
    wr(VAL, 32'd77);
    rd(VAL, 32'd77, "R7 counter 3 written");
    wr(SEL, 0);
    rd(VAL, 32'd10, "R7 counter 0 untouched");
    // R6 / R5 overflow and interrupt
    wr(VAL, 32'hFFFF_FFFE);
    repeat (2) pulse(3, 2'd1);
    rd(VAL, 32'h0, "R2 wrap to zero");
    rd(OVF, 32'h1, "R6 flag set on wrap");
    chk_irq(1'b0, "R5 no irq without enable");
    wr(IE_SET, 32'h1);
    chk_irq(1'b1, "R5 irq with enable");
    rd(IE_CLR, 32'h1, "R5 ie clear reads mask");
    wr(OVF, 32'h0);
    rd(OVF, 32'h1, "R6 zero write keeps flag");
    wr(OVF, 32'h1);
    rd(OVF, 32'h0, "R6 one clears flag");
    chk_irq(1'b0, "R5 irq drops with flag");
    wr(VAL, 32'hFFFF_FFFF);
    reg_wr = 1'b1; reg_addr = OVF; reg_wdata = 32'h1; evt_in[3] = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    rd(OVF, 32'h1, "R6 wrap beats same-cycle clear");
    chk_irq(1'b1, "R5 irq after set-wins");
    wr(IE_CLR, 32'h1);
    chk_irq(1'b0, "R5 ie cleared");
    wr(OVF, 32'h1);
    // R10 reset commands
    wr(VAL, 32'd55);
    wr(CTRL, 32'h3);
    rd(VAL, 32'h0, "R10 event reset counter 0");
    wr(SEL, 3);
    rd(VAL, 32'h0, "R10 event reset counter 3");
    wr(SEL, 0);
    rd(CTRL, 32'h2001, "R1 command bits read zero");
    // R9 cycle counter
    wr(CTRL, 32'h0);
    wr(EN_SET, 32'h8000_0000);
    wr(CYC, 32'h0);
    run_for(9);
    rd(CYC, 32'd10, "R9 one per clock");
    wr(CTRL, 32'h4);
    rd(CYC, 32'h0, "R10 cycle reset");
    wr(CTRL, 32'h9);
    repeat (127) @(negedge clk);
    wr(CTRL, 32'h0);
    rd(CYC, 32'd2, "R9 divide by 64");
    wr(CYC, 32'h0);
    dbg_halt = 1'b1;
    wr(CTRL, 32'h21);
    repeat (9) @(negedge clk);
    wr(CTRL, 32'h0);
    rd(CYC, 32'h0, "R9 debug stop holds");
    run_for(9);
    rd(CYC, 32'd10, "R9 halt ignored without stop bit");
    dbg_halt = 1'b0;
    wr(CYC, 32'hFFFF_FFFF);
    run_for(0);
    rd(CYC, 32'h0, "R9 cycle wrap");
    rd(OVF, 32'h8000_0000, "R6 cycle flag in bit 31");
    wr(OVF, 32'h8000_0000);
    // R12 user access
    wr(UACC, 32'h0);
    priv = 2'd0;
    wr(EN_CLR, 32'h8000_0001);
    rd(EN_SET, 32'h0, "R12 denied read returns zero");
    priv = 2'd1;
    rd(EN_SET, 32'h8000_0001, "R12 denied write dropped");
    wr(UACC, 32'hF);
    priv = 2'd0;
    rd(UACC, 32'hF, "R12 granted read");
    wr(EN_CLR, 32'h8000_0001);
    priv = 2'd1;
    rd(EN_SET, 32'h0, "R12 granted write applied");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      miscompares++;
      $display("FAIL R11 missing read results: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule